// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers level-sensitive interrupt requests into two local groups of eight lines each. A third set of eight "mappable" request lines is folded into both groups. The mappable lines share a single status register. Each local group qualifies that register with its own mappable mask, and the OR of the result replaces one designated status bit of the group, called its cascade bit. Every request line passes through a two-flop synchroniser before it reaches a status register.

For each local group the block drives an active-high level interrupt line and a resolved vector with a valid flag. The interrupt line is high whenever the group's masked pending set is non-zero. The vector carries the tier and the bit, so an interrupt handler can read one value and know which source to serve. When the cascade bit is pending, the vector names the highest qualified mappable source rather than a local bit. Software reaches the four mask registers and the three status registers through a small byte-wide register port with combinational read data.

Top module: `cascade_intc`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset is released, all four mask registers read zero, both interrupt lines are low and both vectors are invalid.
- R2: A change on any request line appears in the status registers, and so at the outputs, on the second rising clock edge after it is applied, and not before.
- R3: A group's interrupt line is high exactly when (status AND local mask) of that group is non-zero, and the vector valid flag equals the interrupt line.
- R4: When the cascade bit is not pending, the vector is {group, index}: group is 2'b00 for local group 0 and 2'b01 for local group 1, and index is the highest set bit of the masked local set, with bit 7 highest.
- R5: The mappable status is shared by both groups. Group 0's cascade bit (status bit 2) equals OR(mappable status AND mappable mask 0), and group 1's cascade bit (status bit 3) equals OR(mappable status AND mappable mask 1). The local request line at a cascade position has no effect.
- R6: When a group's cascade bit is pending, its vector is {2'b10, index} for group 0 or {2'b11, index} for group 1, where index is the highest set bit of (mappable status AND that group's mappable mask). This holds even when higher local bits are also pending.
- R7: When a group's masked set is zero, its interrupt line is low, its valid flag is low and its vector reads 0.
- R8: Register map: address 0 is local mask 0, 1 is local mask 1, 2 is mappable mask 0, 3 is mappable mask 1 (all read/write); 4 is group 0 status, 5 is group 1 status, 6 is mappable status (all read-only); 7 reads 0. Writes to addresses 4 to 7 change nothing.
- R9: A mask register changes only on a clock edge with the write strobe high and its own address, and it then holds the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lreq0_i | input | 8 | Level request lines of local group 0 |
| lreq1_i | input | 8 | Level request lines of local group 1 |
| mreq_i | input | 8 | Level request lines of the shared mappable set |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 8 | Combinational register read data |
| irq0_o | output | 1 | Group 0 interrupt line |
| irq1_o | output | 1 | Group 1 interrupt line |
| vec0_vld_o | output | 1 | Group 0 vector valid |
| vec0_o | output | 5 | Group 0 vector {tier, index} |
| vec1_vld_o | output | 1 | Group 1 vector valid |
| vec1_o | output | 5 | Group 1 vector {tier, index} |

## Verification
The hardest case to reach is a mappable source that is qualified for one group and not the other, while that group also has a higher local bit pending. In that case the vector must come from the mappable tier and ignore the higher local bit. A port-only stimulus has to program the two mappable masks differently and enable the cascade bit in only one local mask. It must also hold the requests long enough to pass the synchroniser. Directed sequences build exactly this overlap. A long run then mixes random request patterns with random register writes, including writes to the read-only addresses. A behavioural model tracks the two-edge input latency and checks every output and the read data on every cycle.

// File: rtl/cintc_pkg.sv
package cintc_pkg;
  localparam int SRC_N  = 8;
  localparam int IDX_W  = $clog2(SRC_N);
  localparam int GRP_W  = 2;
  localparam int VEC_W  = GRP_W + IDX_W;
  localparam int ADDR_W = 3;
  localparam int NGRP   = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_LMASK0 = 3'd0,
    A_LMASK1 = 3'd1,
    A_MMASK0 = 3'd2,
    A_MMASK1 = 3'd3,
    A_STAT0  = 3'd4,
    A_STAT1  = 3'd5,
    A_MSTAT  = 3'd6,
    A_RSVD   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/cintc_rst_sync.sv
module cintc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      rst_n_o <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_n_o <= stage_q;
    end
  end
endmodule

// File: rtl/cintc_sync.sv
module cintc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/cintc_prio_enc.sv
module cintc_prio_enc #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/cintc_group.sv
module cintc_group
  import cintc_pkg::*;
#(
  parameter int W        = SRC_N,
  parameter int CASC_BIT = 2,
  parameter int GRP_ID   = 0,
  parameter int IW       = $clog2(W),
  parameter int VW       = GRP_W + IW
) (
  input  logic [W-1:0]  lstat_i,
  input  logic [W-1:0]  lmask_i,
  input  logic [W-1:0]  mstat_i,
  input  logic [W-1:0]  mmask_i,
  output logic [W-1:0]  stat_o,
  output logic          pend_o,
  output logic          vld_o,
  output logic [VW-1:0] vec_o
);
  logic [W-1:0]  mpend, lpend;
  logic          m_any, l_any;
  logic [IW-1:0] m_idx, l_idx;

  assign mpend = mstat_i & mmask_i;

  // composite status: cascade position carries the folded mappable tier
  always_comb begin
    stat_o           = lstat_i;
    stat_o[CASC_BIT] = |mpend;
  end

  assign lpend = stat_o & lmask_i;

  cintc_prio_enc #(.W(W), .IW(IW)) u_menc (.req_i(mpend), .any_o(m_any), .idx_o(m_idx));
  cintc_prio_enc #(.W(W), .IW(IW)) u_lenc (.req_i(lpend), .any_o(l_any), .idx_o(l_idx));

  always_comb begin
    pend_o = l_any;
    vld_o  = 1'b0;
    vec_o  = '0;
    if (lpend[CASC_BIT]) begin
      vld_o = m_any;
      vec_o = {GRP_W'(GRP_ID + 2), m_idx};
    end else if (l_any) begin
      vld_o = 1'b1;
      vec_o = {GRP_W'(GRP_ID), l_idx};
    end
  end
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
  import cintc_pkg::*;
#(
  parameter int CASC0_BIT = 2,
  parameter int CASC1_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  lreq0_i,
  input  logic [SRC_N-1:0]  lreq1_i,
  input  logic [SRC_N-1:0]  mreq_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [SRC_N-1:0]  reg_wdata_i,
  input  logic              reg_we_i,
  output logic [SRC_N-1:0]  reg_rdata_o,
  output logic              irq0_o,
  output logic              irq1_o,
  output logic              vec0_vld_o,
  output logic [VEC_W-1:0]  vec0_o,
  output logic              vec1_vld_o,
  output logic [VEC_W-1:0]  vec1_o
);
  logic rst_int_n;

  logic [NGRP-1:0][SRC_N-1:0] lreq, lsync, stat;
  logic [NGRP-1:0][SRC_N-1:0] lmask_q, lmask_d, mmask_q, mmask_d;
  logic [NGRP-1:0]            pend, vld;
  logic [NGRP-1:0][VEC_W-1:0] vec;
  logic [SRC_N-1:0]           msync;
  logic                       mask_en;
  reg_addr_e                  sel;

  assign lreq[0] = lreq0_i;
  assign lreq[1] = lreq1_i;
  assign sel     = reg_addr_e'(reg_addr_i);

  cintc_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_int_n));

  cintc_sync #(.W(SRC_N)) u_msync (.clk(clk), .rst_n(rst_int_n), .d_i(mreq_i), .q_o(msync));

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int CB = (g == 0) ? CASC0_BIT : CASC1_BIT;

    cintc_sync #(.W(SRC_N)) u_lsync (
      .clk(clk), .rst_n(rst_int_n), .d_i(lreq[g]), .q_o(lsync[g])
    );

    cintc_group #(.W(SRC_N), .CASC_BIT(CB), .GRP_ID(g)) u_grp (
      .lstat_i(lsync[g]), .lmask_i(lmask_q[g]),
      .mstat_i(msync),    .mmask_i(mmask_q[g]),
      .stat_o(stat[g]),   .pend_o(pend[g]),
      .vld_o(vld[g]),     .vec_o(vec[g])
    );
  end

  // mask next-state with explicit write enable
  assign mask_en = reg_we_i && !reg_addr_i[ADDR_W-1];

  always_comb begin
    lmask_d = lmask_q;
    mmask_d = mmask_q;
    if (mask_en) begin
      case (sel)
        A_LMASK0: lmask_d[0] = reg_wdata_i;
        A_LMASK1: lmask_d[1] = reg_wdata_i;
        A_MMASK0: mmask_d[0] = reg_wdata_i;
        A_MMASK1: mmask_d[1] = reg_wdata_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      lmask_q <= '0;
      mmask_q <= '0;
    end else if (mask_en) begin
      lmask_q <= lmask_d;
      mmask_q <= mmask_d;
    end
  end

  always_comb begin
    case (sel)
      A_LMASK0: reg_rdata_o = lmask_q[0];
      A_LMASK1: reg_rdata_o = lmask_q[1];
      A_MMASK0: reg_rdata_o = mmask_q[0];
      A_MMASK1: reg_rdata_o = mmask_q[1];
      A_STAT0:  reg_rdata_o = stat[0];
      A_STAT1:  reg_rdata_o = stat[1];
      A_MSTAT:  reg_rdata_o = msync;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq0_o     = pend[0];
  assign irq1_o     = pend[1];
  assign vec0_vld_o = vld[0];
  assign vec1_vld_o = vld[1];
  assign vec0_o     = vec[0];
  assign vec1_o     = vec[1];
endmodule

// File: rtl/cintc_chk.sv
module cintc_chk (
  input logic            clk,
  input logic            rst_int_n,
  input logic            reg_we_i,
  input logic [2:0]      reg_addr_i,
  input logic [1:0][7:0] lmask_q,
  input logic [1:0][7:0] mmask_q,
  input logic [7:0]      mreq_i,
  input logic [7:0]      msync,
  input logic            irq0_o,
  input logic            irq1_o,
  input logic            vec0_vld_o,
  input logic [4:0]      vec0_o,
  input logic            vec1_vld_o,
  input logic [4:0]      vec1_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)          age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  // R1
  mask_rst_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (age_q == 2'd0) |-> (lmask_q == '0 && mmask_q == '0));

  // R2
  sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (age_q == 2'd3) |-> (msync == $past(mreq_i, 2)));

  // R3
  pend_vld0_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq0_o == vec0_vld_o);

  // R3
  pend_vld1_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq1_o == vec1_vld_o);

  // R7
  idle_vec0_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !irq0_o |-> (vec0_o == 5'd0));

  // R7
  idle_vec1_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !irq1_o |-> (vec1_o == 5'd0));

  // R6
  casc_src0_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (vec0_vld_o && vec0_o[4:3] == 2'd2) |-> (mmask_q[0] != 8'd0));

  // R6
  casc_src1_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (vec1_vld_o && vec1_o[4:3] == 2'd3) |-> (mmask_q[1] != 8'd0));

  // R4
  tier_grp_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (vec0_vld_o |-> !vec0_o[3]) and (vec1_vld_o |-> vec1_o[3]));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !reg_we_i |=> ($stable(lmask_q) && $stable(mmask_q)));

  // R8
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_we_i && reg_addr_i[2]) |=> ($stable(lmask_q) && $stable(mmask_q)));
endmodule

bind cascade_intc cintc_chk u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .lmask_q(lmask_q), .mmask_q(mmask_q), .mreq_i(mreq_i), .msync(msync),
  .irq0_o(irq0_o), .irq1_o(irq1_o), .vec0_vld_o(vec0_vld_o), .vec0_o(vec0_o),
  .vec1_vld_o(vec1_vld_o), .vec1_o(vec1_o)
);

// File: tb/cascade_intc_test.sv
module cascade_intc_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lreq0 = '0, lreq1 = '0, mreq = '0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq0, irq1, vld0, vld1;
  logic [4:0] vec0, vec1;

  int n_chk = 0;
  int n_fail = 0;
  bit run_cmp = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cascade_intc uut (
    .clk(clk), .rst_n(rst_n), .lreq0_i(lreq0), .lreq1_i(lreq1), .mreq_i(mreq),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_we_i(reg_we),
    .reg_rdata_o(reg_rdata), .irq0_o(irq0), .irq1_o(irq1),
    .vec0_vld_o(vld0), .vec0_o(vec0), .vec1_vld_o(vld1), .vec1_o(vec1)
  );

  // reference model: two-deep input history and mask copies
  logic [7:0] m_lm [2];
  logic [7:0] m_mm [2];
  logic [7:0] m_l1 [2];
  logic [7:0] m_l2 [2];
  logic [7:0] m_m1, m_m2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin
        m_lm[g] = '0; m_mm[g] = '0; m_l1[g] = '0; m_l2[g] = '0;
      end
      m_m1 = '0; m_m2 = '0;
    end else begin
      m_l2[0] = m_l1[0]; m_l2[1] = m_l1[1]; m_m2 = m_m1;
      m_l1[0] = lreq0;   m_l1[1] = lreq1;   m_m1 = mreq;
      if (reg_we) begin
        case (reg_addr)
          3'd0: m_lm[0] = reg_wdata;
          3'd1: m_lm[1] = reg_wdata;
          3'd2: m_mm[0] = reg_wdata;
          3'd3: m_mm[1] = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic int top_bit(logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] exp_stat(int g);
    logic [7:0] s;
    s = m_l2[g];
    s[(g == 0) ? 2 : 3] = ((m_m2 & m_mm[g]) != 0);
    return s;
  endfunction

  // expected {irq, vld, vec}; tag chosen by case
  function automatic logic [6:0] exp_out(int g, output string tag);
    logic [7:0] p;
    int cb;
    cb = (g == 0) ? 2 : 3;
    p  = exp_stat(g) & m_lm[g];
    if (p == 0) begin
      tag = "R7";
      return 7'd0;
    end else if (p[cb]) begin
      tag = "R6";
      return {1'b1, 1'b1, 2'(g + 2), 3'(top_bit(m_m2 & m_mm[g]))};
    end
    tag = "R4";
    return {1'b1, 1'b1, 2'(g), 3'(top_bit(p))};
  endfunction

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return m_lm[0];
      3'd1: return m_lm[1];
      3'd2: return m_mm[0];
      3'd3: return m_mm[1];
      3'd4: return exp_stat(0);
      3'd5: return exp_stat(1);
      3'd6: return m_m2;
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      string t0, t1;
      logic [6:0] e0, e1;
      e0 = exp_out(0, t0);
      e1 = exp_out(1, t1);
      chk("R3 irq0", {7'd0, irq0}, {7'd0, e0[6]});
      chk("R3 irq1", {7'd0, irq1}, {7'd0, e1[6]});
      chk({t0, " vec0"}, {2'd0, vld0, vec0}, {2'd0, e0[5:0]});
      chk({t1, " vec1"}, {2'd0, vld1, vec1}, {2'd0, e1[5:0]});
      chk((reg_addr < 4) ? "R9 rdata" : (reg_addr == 7) ? "R8 rdata" : "R2 rdata",
          reg_rdata, exp_rd(reg_addr));
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic setin(logic [7:0] l0, logic [7:0] l1, logic [7:0] m);
    @(negedge clk); #1;
    lreq0 = l0; lreq1 = l1; mreq = m;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk); #1;
      reg_addr = reg_addr + 3'd1;
    end
  endtask

  // sample at a quarter period after the negative edge
  task automatic rd(logic [2:0] a, output logic [7:0] v);
    @(negedge clk); #1;
    reg_addr = a;
    #(CLK_P/4);
    v = reg_rdata;
  endtask

  task automatic check_reset_state();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), v);
      chk("R1 mask", v, 8'd0);
    end
    chk("R1 irq/vld", {4'd0, irq0, irq1, vld0, vld1}, 8'd0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    #(CLK_P * 3 + 2);
    chk("R1 in reset", {4'd0, irq0, irq1, vld0, vld1}, 8'd0);
    rst_n = 1'b1;
    idle(4);
    run_cmp = 1'b1;
    check_reset_state();

    // R5: local line at cascade position has no effect
    wr(3'd0, 8'h04);
    setin(8'h04, 8'h00, 8'h00);
    idle(3);
    chk("R5 local at cascade ignored", {7'd0, irq0}, 8'd0);

    // R6: mappable tier, different masks per group
    wr(3'd2, 8'h10);
    wr(3'd3, 8'h20);
    wr(3'd1, 8'h08);
    setin(8'h00, 8'h00, 8'h30);
    idle(3);
    chk("R6 vec0 mappable", {2'd0, vld0, vec0}, {2'd0, 1'b1, 5'b10100});
    chk("R6 vec1 mappable", {2'd0, vld1, vec1}, {2'd0, 1'b1, 5'b11101});
    rd(3'd6, v);
    chk("R5 shared map status", v, 8'h30);

    // R6: cascade wins over higher local bit
    wr(3'd0, 8'h84);
    setin(8'h80, 8'h00, 8'h30);
    idle(3);
    chk("R6 cascade over local", {3'd0, vec0}, {3'd0, 5'b10100});

    // R4: cascade masked off, local bit 7 wins
    wr(3'd2, 8'h00);
    idle(1);
    chk("R4 local vec", {2'd0, vld0, vec0}, {2'd0, 1'b1, 5'b00111});

    // R2: two-edge latency
    wr(3'd1, 8'h01);
    setin(8'h80, 8'h01, 8'h00);
    chk("R2 before edge", {7'd0, irq1}, 8'd0);
    @(negedge clk);
    chk("R2 after one edge", {7'd0, irq1}, 8'd0);
    @(negedge clk);
    chk("R2 after two edges", {2'd0, vld1, vec1}, {2'd0, 1'b1, 5'b01000});

    // R8: read-only and reserved addresses ignore writes
    for (int a = 4; a < 8; a++) wr(3'(a), 8'hFF);
    rd(3'd1, v); chk("R8 lmask1 kept", v, 8'h01);
    rd(3'd3, v); chk("R8 mmask1 kept", v, 8'h20);
    rd(3'd7, v); chk("R8 reserved", v, 8'h00);

    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk); #1;
      lreq0 = 8'($urandom); lreq1 = 8'($urandom); mreq = 8'($urandom);
      reg_addr = 3'($urandom);
      reg_wdata = 8'($urandom);
      reg_we = (($urandom % 4) == 0);
    end
    @(negedge clk); #1;
    reg_we = 1'b0;

    // R1: reset mid-run clears masks
    setin(8'h00, 8'h00, 8'h00);
    wr(3'd2, 8'h5A);
    idle(3);
    run_cmp = 1'b0;
    @(negedge clk); #1; rst_n = 1'b0;
    @(negedge clk); #1; rst_n = 1'b1;
    idle(4);
    run_cmp = 1'b1;
    check_reset_state();
    idle(2);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule